// File: doc/BRIEF.md
# Shared Interleaved Memory Front End

This block sits in front of a word-addressed memory made of two to four storage modules and serves four requester ports. Port 0 belongs to the processor and ports 1 to 3 to I/O channels. Each port presents an 18-bit word address. Its own per-module base fields and its own interleave mode decide which module, if any, answers. Only one transfer runs at a time. Once a port is accepted, the whole memory stays busy for a fixed cycle length, even for ports that target a different module. The read word returns after a fixed access delay.

Each stored word carries an even parity bit. The bit is generated on store and checked on fetch. Separate enable masks switch off whole ports or whole modules. A request that no enabled module claims, or that comes from a disabled port, is never granted. After a timeout it is retired with a non-existent-memory response.

The request side of each port is valid/ready. A requester raises valid with its address, direction and write data and holds all of them stable until it sees ready high at a clock edge. Ready is the only back-pressure. The response is a one-cycle pulse on the port's response valid bit and cannot be stalled, because the requester is always waiting for it. Address bits are named big-endian from 18 (most significant, `req_addr[17]`) to 35 (least significant, `req_addr[0]`).

Top module: `mport_mem_arbiter`

## Requirements
- R1: In mode 0 (`cfg_ilv` field 2'b00, and 2'b11 behaves the same), module m answers port p when `addr[17:15]` equals the 3-bit base field of port p for module m, at `cfg_base[(p*NMOD+m)*3 +: 3]`. The word offset is `addr[14:0]`.
- R2: In mode 1 (2'b01, two-way), the select field is `{addr[17], addr[16], addr[0]}`, so bit 35 takes the place of bit 20. The offset is `{addr[14:1], addr[15]}`.
- R3: In mode 2 (2'b10, four-way), the select field is `{addr[17], addr[1], addr[0]}`, so bits 34 and 35 replace bits 19 and 20. The offset is `{addr[14:2], addr[16:15]}`.
- R4: A module whose `cfg_mod_en` bit is 0 answers no port. When several enabled modules match, the one with the lowest index answers.
- R5: Among ports holding a claimable request while the memory is idle, the lowest port index is accepted. At most one port is granted per cycle.
- R6: A grant is accepted in cycle c. `busy` is then high in cycles c+1 through c+CYC_CYC-1, and no port is granted before cycle c+CYC_CYC.
- R7: For a granted request accepted in cycle c, the port's `rsp_valid` bit is high only in cycle c+ACC_CYC, with `rsp_nxm` low. On a read, `rsp_rdata` is the word last stored at that module and offset.
- R8: A granted write stores its data at the acceptance edge. Its response in cycle c+ACC_CYC returns the word now held there.
- R9: `rsp_par` is the stored parity bit, equal to the XOR of all stored data bits. `rsp_perr` is 1 exactly when that XOR disagrees with the stored bit, so it is 0 for words written through the block.
- R10: A request from a port whose `cfg_port_en` bit is 0, or that no enabled module claims, is never granted and touches no storage. If valid is held for NXM_CYC cycles, ready is high in the last of them, and the next cycle carries `rsp_valid` and `rsp_nxm` both high for that port.
- R11: Each module keeps 2^STORE_AW words. The storage row is the offset modulo 2^STORE_AW, so offsets that are equal in those low bits share one word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_port_en | input | NPORT | Per-port enable |
| cfg_mod_en | input | NMOD | Per-module enable |
| cfg_ilv | input | 2*NPORT | Per-port interleave mode, 2 bits each |
| cfg_base | input | 3*NPORT*NMOD | Per-port, per-module base select fields |
| req_valid | input | NPORT | Request valid per port |
| req_ready | output | NPORT | Request accepted (grant or timeout retire) |
| req_write | input | NPORT | 1 = store, 0 = fetch |
| req_addr | input | 18*NPORT | Word address per port |
| req_wdata | input | DATA_W*NPORT | Store data per port |
| rsp_valid | output | NPORT | One-cycle response pulse per port |
| rsp_nxm | output | NPORT | Response is a non-existent-memory timeout |
| rsp_rdata | output | DATA_W | Word returned by the memory response |
| rsp_par | output | 1 | Stored parity bit of the returned word |
| rsp_perr | output | 1 | Parity mismatch on the returned word |
| busy | output | 1 | A memory cycle is in progress |

## Verification
The decode is tried with the same module reached through ports in different modes. A word stored through a two-way or four-way port is read back through a plain port at the module and offset the requirement predicts. This separates a correct bit swap from a wrong one, or from no swap at all. Simultaneous requests from all four ports from idle expose both the priority order and the spacing forced by the global lock. Overlapping bases, disabled modules and disabled ports tell lowest-index selection, module masking and timeout retirement apart. A write through a disabled port is followed by a read of the word it would have hit. Constrained random configurations with a small address pool then mix all modes, aliasing rows and timeouts against a bench model.

// File: rtl/mma_pkg.sv
package mma_pkg;
  localparam int ADDR_W = 18;
  localparam int BLK_W  = 15;
  localparam int SEL_W  = ADDR_W - BLK_W;

  typedef enum logic [1:0] {
    ILV_NONE = 2'd0,
    ILV_TWO  = 2'd1,
    ILV_FOUR = 2'd2
  } ilv_e;

  // module select field; low-order bits 35/34 stand in for bits 20/19
  function automatic logic [SEL_W-1:0] sel_field(logic [ADDR_W-1:0] a, logic [1:0] mode);
    case (mode)
      ILV_TWO:  return {a[17], a[16], a[0]};
      ILV_FOUR: return {a[17], a[1], a[0]};
      default:  return a[17:15];
    endcase
  endfunction

  // in-module word offset; the displaced high bits fill the vacated low ones
  function automatic logic [BLK_W-1:0] blk_offset(logic [ADDR_W-1:0] a, logic [1:0] mode);
    case (mode)
      ILV_TWO:  return {a[14:1], a[15]};
      ILV_FOUR: return {a[14:2], a[16:15]};
      default:  return a[14:0];
    endcase
  endfunction
endpackage

// File: rtl/mma_decode.sv
module mma_decode import mma_pkg::*; #(
  parameter int NMOD   = 4,
  parameter int MIDX_W = 2
) (
  input  logic [ADDR_W-1:0]      addr,
  input  logic [1:0]             mode,
  input  logic [NMOD*SEL_W-1:0]  base,
  input  logic [NMOD-1:0]        mod_en,
  output logic                   hit,
  output logic [MIDX_W-1:0]      mod_idx,
  output logic [BLK_W-1:0]       offset
);
  logic [SEL_W-1:0] sel;

  assign sel    = sel_field(addr, mode);
  assign offset = blk_offset(addr, mode);

  // descending scan so the lowest matching module wins
  always_comb begin
    hit     = 1'b0;
    mod_idx = '0;
    for (int m = NMOD - 1; m >= 0; m--) begin
      if (mod_en[m] && (sel == base[m*SEL_W +: SEL_W])) begin
        hit     = 1'b1;
        mod_idx = MIDX_W'(m);
      end
    end
  end
endmodule

// File: rtl/mma_prio.sv
module mma_prio #(
  parameter int N = 4
) (
  input  logic [N-1:0] req,
  output logic [N-1:0] gnt
);
  always_comb begin
    logic found;
    found = 1'b0;
    gnt   = '0;
    for (int i = 0; i < N; i++) begin
      if (req[i] && !found) begin
        gnt[i] = 1'b1;
        found  = 1'b1;
      end
    end
  end
endmodule

// File: rtl/mma_store.sv
module mma_store import mma_pkg::*; #(
  parameter int NMOD     = 4,
  parameter int STORE_AW = 8,
  parameter int DATA_W   = 36,
  parameter int MIDX_W   = 2
) (
  input  logic              clk,
  input  logic              we,
  input  logic [MIDX_W-1:0] wmod,
  input  logic [BLK_W-1:0]  woff,
  input  logic [DATA_W-1:0] wdata,
  input  logic [MIDX_W-1:0] rmod,
  input  logic [BLK_W-1:0]  roff,
  output logic [DATA_W-1:0] rdata,
  output logic              rpar
);
  localparam int DEPTH = 1 << STORE_AW;
  localparam int WORDS = NMOD * DEPTH;
  localparam int IDX_W = $clog2(WORDS);

  logic [DATA_W:0]  mem [WORDS];
  logic [IDX_W-1:0] widx, ridx;

  assign widx = IDX_W'(int'(wmod) * DEPTH + int'(woff) % DEPTH);
  assign ridx = IDX_W'(int'(rmod) * DEPTH + int'(roff) % DEPTH);

  always_ff @(posedge clk) begin
    if (we) mem[widx] <= {^wdata, wdata};
  end

  assign {rpar, rdata} = mem[ridx];
endmodule

// File: rtl/mport_mem_arbiter.sv
module mport_mem_arbiter import mma_pkg::*; #(
  parameter int NPORT    = 4,
  parameter int NMOD     = 4,
  parameter int DATA_W   = 36,
  parameter int STORE_AW = 8,
  parameter int ACC_CYC  = 200,
  parameter int CYC_CYC  = 450,
  parameter int NXM_CYC  = 1000
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [NPORT-1:0]          cfg_port_en,
  input  logic [NMOD-1:0]           cfg_mod_en,
  input  logic [2*NPORT-1:0]        cfg_ilv,
  input  logic [SEL_W*NPORT*NMOD-1:0] cfg_base,
  input  logic [NPORT-1:0]          req_valid,
  output logic [NPORT-1:0]          req_ready,
  input  logic [NPORT-1:0]          req_write,
  input  logic [ADDR_W*NPORT-1:0]   req_addr,
  input  logic [DATA_W*NPORT-1:0]   req_wdata,
  output logic [NPORT-1:0]          rsp_valid,
  output logic [NPORT-1:0]          rsp_nxm,
  output logic [DATA_W-1:0]         rsp_rdata,
  output logic                      rsp_par,
  output logic                      rsp_perr,
  output logic                      busy
);
  localparam int PIDX_W = (NPORT > 1) ? $clog2(NPORT) : 1;
  localparam int MIDX_W = (NMOD > 1) ? $clog2(NMOD) : 1;
  localparam int CNT_W  = $clog2(CYC_CYC + 1);
  localparam int NX_W   = $clog2(NXM_CYC + 1);

  logic [NPORT-1:0]  hit, ok, cand, gnt, bad, nxm_take, nxm_rsp_q;
  logic [MIDX_W-1:0] p_mod [NPORT];
  logic [BLK_W-1:0]  p_off [NPORT];

  logic              busy_q, mem_rsp_q, par_q, perr_q;
  logic [CNT_W-1:0]  cnt;
  logic [PIDX_W-1:0] cur_port, sel_port;
  logic [MIDX_W-1:0] cur_mod, sel_mod;
  logic [BLK_W-1:0]  cur_off, sel_off;
  logic              sel_we;
  logic [DATA_W-1:0] sel_wd, st_rd, rdata_q;
  logic              st_par;

  assign ok   = hit & cfg_port_en;
  assign bad  = req_valid & ~ok;
  assign cand = req_valid & ok & {NPORT{~busy_q}};

  for (genvar p = 0; p < NPORT; p++) begin : g_port
    logic [NX_W-1:0] nx_cnt;

    mma_decode #(.NMOD(NMOD), .MIDX_W(MIDX_W)) u_dec (
      .addr    (req_addr[p*ADDR_W +: ADDR_W]),
      .mode    (cfg_ilv[p*2 +: 2]),
      .base    (cfg_base[p*NMOD*SEL_W +: NMOD*SEL_W]),
      .mod_en  (cfg_mod_en),
      .hit     (hit[p]),
      .mod_idx (p_mod[p]),
      .offset  (p_off[p])
    );

    // unclaimed request: count held cycles, retire with a timeout response
    assign nxm_take[p] = bad[p] && (nx_cnt == NX_W'(NXM_CYC - 1));

    always_ff @(posedge clk) begin
      if (!rst_n)                       nx_cnt <= '0;
      else if (bad[p] && !nxm_take[p])  nx_cnt <= nx_cnt + 1'b1;
      else                              nx_cnt <= '0;
    end
  end

  mma_prio #(.N(NPORT)) u_prio (.req(cand), .gnt(gnt));

  always_comb begin
    sel_port = '0;
    sel_mod  = '0;
    sel_off  = '0;
    sel_we   = 1'b0;
    sel_wd   = '0;
    for (int p = 0; p < NPORT; p++) begin
      if (gnt[p]) begin
        sel_port = PIDX_W'(p);
        sel_mod  = p_mod[p];
        sel_off  = p_off[p];
        sel_we   = req_write[p];
        sel_wd   = req_wdata[p*DATA_W +: DATA_W];
      end
    end
  end

  mma_store #(.NMOD(NMOD), .STORE_AW(STORE_AW), .DATA_W(DATA_W), .MIDX_W(MIDX_W)) u_store (
    .clk   (clk),
    .we    (|gnt && sel_we),
    .wmod  (sel_mod),
    .woff  (sel_off),
    .wdata (sel_wd),
    .rmod  (cur_mod),
    .roff  (cur_off),
    .rdata (st_rd),
    .rpar  (st_par)
  );

  // one cycle counter times access and full cycle for the whole memory
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q    <= 1'b0;
      cnt       <= '0;
      cur_port  <= '0;
      cur_mod   <= '0;
      cur_off   <= '0;
      mem_rsp_q <= 1'b0;
      rdata_q   <= '0;
      par_q     <= 1'b0;
      perr_q    <= 1'b0;
      nxm_rsp_q <= '0;
    end else begin
      nxm_rsp_q <= nxm_take;
      mem_rsp_q <= 1'b0;
      if (!busy_q) begin
        if (|gnt) begin
          busy_q   <= 1'b1;
          cnt      <= CNT_W'(1);
          cur_port <= sel_port;
          cur_mod  <= sel_mod;
          cur_off  <= sel_off;
        end
      end else begin
        cnt <= cnt + 1'b1;
        if (cnt == CNT_W'(ACC_CYC - 1)) begin
          mem_rsp_q <= 1'b1;
          rdata_q   <= st_rd;
          par_q     <= st_par;
          perr_q    <= ^{st_par, st_rd};
        end
        if (cnt == CNT_W'(CYC_CYC - 1)) busy_q <= 1'b0;
      end
    end
  end

  // cur_port holds until the next grant, which is later than the response
  always_comb begin
    rsp_valid = nxm_rsp_q;
    if (mem_rsp_q) rsp_valid[cur_port] = 1'b1;
  end

  assign req_ready = gnt | nxm_take;
  assign rsp_nxm   = nxm_rsp_q;
  assign rsp_rdata = rdata_q;
  assign rsp_par   = par_q;
  assign rsp_perr  = perr_q;
  assign busy      = busy_q;
endmodule

// File: rtl/mma_chk.sv
module mma_chk #(
  parameter int NPORT   = 4,
  parameter int DATA_W  = 36,
  parameter int ACC_CYC = 200,
  parameter int CYC_CYC = 450
) (
  input logic              clk,
  input logic              rst_n,
  input logic [NPORT-1:0]  gnt,
  input logic              busy,
  input logic [NPORT-1:0]  rsp_valid,
  input logic [NPORT-1:0]  rsp_nxm,
  input logic [DATA_W-1:0] rsp_rdata,
  input logic              rsp_par,
  input logic              rsp_perr
);
  localparam int W = $clog2(CYC_CYC + 2);

  logic [W-1:0] busy_run, since_g;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_run <= '0;
      since_g  <= '0;
    end else begin
      busy_run <= busy ? busy_run + 1'b1 : '0;
      if (|gnt)                                since_g <= W'(1);
      else if (since_g != '0 && since_g < W'(CYC_CYC)) since_g <= since_g + 1'b1;
    end
  end

  assert_single_grant_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(gnt));

  assert_grant_locks_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (|gnt) |=> busy);

  assert_lock_length_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (busy_run == W'(CYC_CYC - 1)));

  assert_one_mem_rsp_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(rsp_valid & ~rsp_nxm) <= 1);

  assert_rsp_latency_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (|(rsp_valid & ~rsp_nxm)) |-> (since_g == W'(ACC_CYC)));

  assert_parity_flag_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (|(rsp_valid & ~rsp_nxm)) |-> (rsp_perr == (rsp_par ^ (^rsp_rdata))));

  assert_nxm_is_rsp_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_nxm & ~rsp_valid) == '0);
endmodule

bind mport_mem_arbiter mma_chk #(
  .NPORT(NPORT), .DATA_W(DATA_W), .ACC_CYC(ACC_CYC), .CYC_CYC(CYC_CYC)
) u_chk (
  .clk(clk), .rst_n(rst_n), .gnt(gnt), .busy(busy),
  .rsp_valid(rsp_valid), .rsp_nxm(rsp_nxm), .rsp_rdata(rsp_rdata),
  .rsp_par(rsp_par), .rsp_perr(rsp_perr)
);

// File: tb/mport_mem_arbiter_tb.sv
module mport_mem_arbiter_tb;
  localparam int NP  = 4;
  localparam int NM  = 4;
  localparam int DW  = 36;
  localparam int SAW = 6;
  localparam int ACC = 4;
  localparam int CYC = 9;
  localparam int NXM = 5;
  localparam int DEP = 1 << SAW;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [NP-1:0]      port_en = '1;
  logic [NM-1:0]      mod_en  = '1;
  logic [2*NP-1:0]    ilv     = '0;
  logic [3*NP*NM-1:0] base    = '0;
  logic [NP-1:0]      req_valid = '0, req_write = '0;
  logic [18*NP-1:0]   req_addr  = '0;
  logic [DW*NP-1:0]   req_wdata = '0;
  logic [NP-1:0]      req_ready, rsp_valid, rsp_nxm;
  logic [DW-1:0]      rsp_rdata;
  logic               rsp_par, rsp_perr, busy;

  int nchk = 0, nfail = 0;
  logic [DW-1:0] mdl [NM*DEP];
  bit            mv  [NM*DEP];

  always #2 clk = ~clk;

  mport_mem_arbiter #(
    .NPORT(NP), .NMOD(NM), .DATA_W(DW), .STORE_AW(SAW),
    .ACC_CYC(ACC), .CYC_CYC(CYC), .NXM_CYC(NXM)
  ) u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_port_en(port_en), .cfg_mod_en(mod_en),
    .cfg_ilv(ilv), .cfg_base(base), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_nxm(rsp_nxm), .rsp_rdata(rsp_rdata),
    .rsp_par(rsp_par), .rsp_perr(rsp_perr), .busy(busy)
  );

  task automatic chk(input string what, input logic [63:0] act, input logic [63:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s: actual %0h expected %0h", what, act, exp);
    end
  endtask

  function automatic logic [2:0] b_sel(logic [17:0] a, logic [1:0] md);
    if (md == 2'd1) return {a[17], a[16], a[0]};
    if (md == 2'd2) return {a[17], a[1], a[0]};
    return a[17:15];
  endfunction

  function automatic logic [14:0] b_off(logic [17:0] a, logic [1:0] md);
    if (md == 2'd1) return {a[14:1], a[15]};
    if (md == 2'd2) return {a[14:2], a[16:15]};
    return a[14:0];
  endfunction

  function automatic int b_mod(int p, logic [17:0] a);
    if (!port_en[p]) return -1;
    for (int m = 0; m < NM; m++)
      if (mod_en[m] && base[(p*NM+m)*3 +: 3] == b_sel(a, ilv[p*2 +: 2])) return m;
    return -1;
  endfunction

  task automatic set_plain();
    ilv = '0; port_en = '1; mod_en = '1;
    for (int p = 0; p < NP; p++)
      for (int m = 0; m < NM; m++) base[(p*NM+m)*3 +: 3] = 3'(m);
  endtask

  task automatic wait_idle();
    while (busy) @(negedge clk);
  endtask

  task automatic xact(input int p, input logic [17:0] a, input bit we,
                      input logic [DW-1:0] wd, input string tag);
    int m, k, j, idx;
    m = b_mod(p, a);
    @(negedge clk);
    req_valid[p] = 1'b1; req_write[p] = we;
    req_addr[p*18 +: 18] = a; req_wdata[p*DW +: DW] = wd;
    k = 0; #1;
    while (!req_ready[p] && k < 400) begin @(negedge clk); #1; k++; end
    @(negedge clk);
    req_valid[p] = 1'b0; #1;
    if (m < 0) begin
      chk({tag, " R10 timeout length"}, 64'(k), 64'(NXM - 1));
      chk({tag, " R10 timeout response"}, {rsp_valid[p], rsp_nxm[p]}, 2'b11);
    end else begin
      idx = m * DEP + int'(b_off(a, ilv[p*2 +: 2])) % DEP;
      if (we) begin mdl[idx] = wd; mv[idx] = 1'b1; end
      j = 1;
      while (!rsp_valid[p] && j < 100) begin @(negedge clk); #1; j++; end
      chk({tag, " R7 latency"}, 64'(j), 64'(ACC));
      chk({tag, " R7 nxm low"}, 64'(rsp_nxm[p]), 64'(0));
      if (mv[idx]) chk({tag, " R8 data"}, 64'(rsp_rdata), 64'(mdl[idx]));
      chk({tag, " R9 parity"}, 64'(rsp_par), 64'(^rsp_rdata));
      chk({tag, " R9 perr"}, 64'(rsp_perr), 64'(0));
    end
  endtask

  initial begin
    #(4 * 100000);
    nchk++; nfail++;
    $display("FAIL watchdog: actual hung expected done");
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end

  initial begin
    int tacc [NP];
    int ord  [NP];
    int t, n;
    logic [17:0] pool [16];
    void'($urandom(32'd1234));
    for (int i = 0; i < NM*DEP; i++) mv[i] = 1'b0;
    set_plain();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk); #1;
    chk("R6 reset busy", 64'(busy), 64'(0));
    chk("R5 reset ready", 64'(req_ready), 64'(0));
    chk("R7 reset rsp", 64'(rsp_valid), 64'(0));

    // R1 plain decode, cross-port readback
    xact(0, 18'h00011, 1, 36'hA5A5A5A51, "R1");
    xact(1, 18'h00011, 0, 0, "R1");
    xact(2, 18'h08022, 1, 36'h123456789, "R1");
    xact(3, 18'h08022, 0, 0, "R1");
    xact(0, 18'h1FFFF, 1, 36'hFFFFFFFFF, "R1");
    xact(1, 18'h1FFFF, 0, 0, "R1");

    // R2 two-way port writes, plain port reads module 1 offset 0
    ilv[1*2 +: 2] = 2'd1;
    xact(1, 18'h00001, 1, 36'h0BEEF0001, "R2");
    xact(0, 18'h08000, 0, 0, "R2");
    // R3 four-way port writes, plain port reads module 3 offset 0
    ilv[2*2 +: 2] = 2'd2;
    xact(2, 18'h00003, 1, 36'h0CAFE0003, "R3");
    xact(0, 18'h18000, 0, 0, "R3");
    xact(2, 18'h00006, 1, 36'h777000006, "R3");
    xact(0, 18'h08001, 0, 0, "R3");

    // R4 overlap and module disable
    base[(3*NM+0)*3 +: 3] = 3'd5;
    base[(3*NM+2)*3 +: 3] = 3'd5;
    xact(3, 18'h28004, 1, 36'h44440000A, "R4");
    xact(0, 18'h00004, 0, 0, "R4");
    mod_en[0] = 1'b0;
    xact(3, 18'h28004, 1, 36'h44440000B, "R4");
    xact(1, 18'h00004, 0, 0, "R4");
    mod_en[0] = 1'b1;
    xact(0, 18'h10004, 0, 0, "R4");
    mod_en[2] = 1'b0;
    xact(0, 18'h10004, 0, 0, "R4");
    mod_en[2] = 1'b1;

    // R10 disabled port: no write effect
    set_plain();
    xact(0, 18'h00030, 1, 36'h0000000AA, "R10");
    port_en[2] = 1'b0;
    xact(2, 18'h00030, 1, 36'h0000000BB, "R10");
    port_en[2] = 1'b1;
    xact(1, 18'h00030, 0, 0, "R10");

    // R11 aliasing rows
    xact(0, 18'h00005, 1, 36'h111111111, "R11");
    xact(0, 18'h00045, 1, 36'h222222222, "R11");
    xact(1, 18'h00005, 0, 0, "R11");

    // R5 priority and R6 spacing
    wait_idle();
    @(negedge clk);
    for (int p = 0; p < NP; p++) begin
      req_valid[p] = 1'b1; req_write[p] = 1'b0;
      req_addr[p*18 +: 18] = 18'(p * 32768);
    end
    #1;
    chk("R5 first grant", 64'(req_ready), 64'(1));
    t = 0; n = 0;
    while (n < NP && t < 200) begin
      for (int p = 0; p < NP; p++)
        if (req_ready[p] && req_valid[p]) begin ord[n] = p; tacc[n] = t; n++; end
      @(negedge clk); t++;
      for (int p = 0; p < NP; p++)
        if (n > 0 && ord[n-1] == p) req_valid[p] = 1'b0;
      #1;
    end
    chk("R5 all granted", 64'(n), 64'(NP));
    for (int i = 0; i < NP; i++) chk("R5 order", 64'(ord[i]), 64'(i));
    for (int i = 1; i < NP; i++) chk("R6 grant spacing", 64'(tacc[i] - tacc[i-1]), 64'(CYC));
    req_valid = '0;
    repeat (CYC + 2) @(negedge clk);

    // random configurations and traffic
    for (int r = 0; r < 6; r++) begin
      for (int p = 0; p < NP; p++) begin
        ilv[p*2 +: 2] = 2'($urandom % 3);
        port_en[p] = ($urandom % 8) != 0;
        for (int m = 0; m < NM; m++) base[(p*NM+m)*3 +: 3] = 3'($urandom);
      end
      for (int m = 0; m < NM; m++) mod_en[m] = ($urandom % 8) != 0;
      for (int i = 0; i < 16; i++) pool[i] = 18'($urandom);
      for (int i = 0; i < 30; i++)
        xact($urandom % NP, pool[$urandom % 16], ($urandom % 2) == 1,
             {4'($urandom), 32'($urandom)}, "RND");
    end

    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end
endmodule